// File: doc/BRIEF.md
# Frame-Triplet Capture Status Controller

This block is the control and status side of a frame grabber that delivers images in sets of three. A capture front end pulses `frame_rdy` each time it has buffered a frame. A DMA engine pulses `dma_done` each time it has moved one frame out. The block tracks which frame of the current set is next in line for transfer, and raises a level interrupt while work is waiting. It also latches changes of a cable-present input and counts sets it had to throw away because the host never set up their transfers.

Software uses a small 32-bit register port with four word registers. They hold a read-only frame length in 4096-byte pages, a two-bit control field that gates interrupts and frame buffering, a status word, and the live cable level. Clearing the transfer-interrupt enable empties the frame buffer and stops buffering, so capture always restarts at the first frame of a set.

Top module: `tri_capture_ctl`

## Requirements
- R1: After reset the control register (byte offset 0x4) and the status register (offset 0x8) read 0, and `irq` is low.
- R2: Offset 0x0 reads the parameter `FRAME_PAGES`. Offset 0x4 reads back bits 1:0 as last written, and its other bits read 0.
- R3: Status bits 1:0 hold the 1-based position (1, 2 or 3) of the oldest buffered frame of the current set not yet transferred, or 0 when nothing waits.
- R4: A `dma_done` pulse while a frame waits marks it transferred. If frame i (0-based) was moved, the index becomes i+2 when that frame is buffered and 0 otherwise, and status bit 2 sets. A `dma_done` pulse with nothing waiting changes nothing.
- R5: Writing status with bit 2 or bit 3 set clears that flag. A flag that sets in the same cycle as its clear stays set.
- R6: A frame arriving after all three frames of a set were buffered starts a new set. If any frame of the old set was still untransferred, the old set is discarded, the drop count increments and the index reads 1.
- R7: Status bits 15:8 hold the drop count. It saturates at 255 and clears on a status read. The read returns the value before clearing, and a drop in the same cycle as the read leaves 1.
- R8: While control bit 0 is 0, the set state is cleared and `frame_rdy` is ignored. A control update takes effect from the cycle after the write.
- R9: While `cable_in` is low the set state is cleared and frames are ignored. Any change of `cable_in` after the first cycle out of reset sets status bit 3. Offset 0xC bit 0 reads `cable_in`.
- R10: `irq` = (control bit 0 and (index nonzero or bit 2 set)) or (control bit 1 and bit 3 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears the drop count) |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| frame_rdy | input | 1 | One-cycle pulse: a frame has been buffered |
| dma_done | input | 1 | One-cycle pulse: one frame transfer finished |
| cable_in | input | 1 | Cable present level, synchronous to clk |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `frame_rdy`, `dma_done` and `cable_in` are synchronous to `clk`. They also assume each pulse lasts one cycle per event, and that the bus strobes are sampled only on the edge where they are high. The bench changes every input on the falling edge and drops the pulse inputs after one cycle. Its stimulus includes same-cycle collisions: a transfer with a new frame, a status read with a drop, and a flag clear with a flag set. These are the cases where the ordering rules decide the outcome.

// File: rtl/tricap_pkg.sv
package tricap_pkg;
  localparam int FRAMES_PER_SET = 3;
  localparam int POS_W = $clog2(FRAMES_PER_SET + 1);
  localparam int ST_DONE_BIT = 2;
  localparam int ST_CHG_BIT = 3;
  localparam int ST_DROP_LSB = 8;

  typedef enum logic [1:0] {
    SEL_FSIZE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_CABLE = 2'd3
  } reg_sel_e;

  // 1-based position of the oldest captured, untransferred frame; 0 if none
  function automatic logic [POS_W-1:0] next_pending(input logic [POS_W-1:0] cap,
                                                    input logic [POS_W-1:0] xfr);
    return (xfr < cap) ? POS_W'(xfr + 1'b1) : '0;
  endfunction
endpackage

// File: rtl/tricap_seq.sv
module tricap_seq
  import tricap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clear,
  input  logic             frame_rdy,
  input  logic             dma_done,
  output logic [POS_W-1:0] pend_idx,
  output logic             done_ev,
  output logic             drop_ev,
  output logic             frame_take
);
  localparam logic [POS_W-1:0] FULL = POS_W'(FRAMES_PER_SET);

  logic [POS_W-1:0] cap_q, xfr_q, cap_d, xfr_d;

  always_comb begin
    cap_d      = cap_q;
    xfr_d      = xfr_q;
    done_ev    = 1'b0;
    drop_ev    = 1'b0;
    frame_take = 1'b0;
    if (hold_clear) begin
      cap_d = '0;
      xfr_d = '0;
    end else begin
      if (dma_done && (xfr_q < cap_q)) begin
        xfr_d   = xfr_q + 1'b1;
        done_ev = 1'b1;
      end
      if (frame_rdy) begin
        frame_take = 1'b1;
        if (cap_q == FULL) begin
          drop_ev = (xfr_d != FULL);
          cap_d   = POS_W'(1);
          xfr_d   = '0;
        end else begin
          cap_d = cap_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      xfr_q <= '0;
    end else begin
      cap_q <= cap_d;
      xfr_q <= xfr_d;
    end
  end

  assign pend_idx = next_pending(cap_q, xfr_q);

  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !frame_take) |=> (pend_idx == '0 || pend_idx == $past(pend_idx) + 1'b1));

  assert_new_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> (pend_idx == POS_W'(1)));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> (pend_idx == '0));
endmodule

// File: rtl/tricap_dropcnt.sv
module tricap_dropcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] cur,
                                                input logic up, input logic wipe);
    if (wipe) return up ? CNT_W'(1) : '0;
    if (up && cur != TOP) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= sat_next(count, inc, clr);
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count >= $past(count)));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/tricap_cable.sv
module tricap_cable (
  input  logic clk,
  input  logic rst_n,
  input  logic cable_in,
  output logic chg_ev
);
  logic prev_q, valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= cable_in;
      valid_q <= 1'b1;
    end
  end

  assign chg_ev = valid_q && (cable_in != prev_q);
endmodule

// File: rtl/tri_capture_ctl.sv
module tri_capture_ctl
  import tricap_pkg::*;
#(
  parameter logic [31:0] FRAME_PAGES = 32'd5,
  parameter int          DROP_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        frame_rdy,
  input  logic        dma_done,
  input  logic        cable_in,
  output logic        irq
);
  reg_sel_e         sel;
  logic [1:0]       ctrl_q;
  logic             done_q, chg_q;
  logic             wr_ctrl, wr_stat, rd_stat, hold_clear;
  logic [POS_W-1:0] pend_idx;
  logic             done_ev, drop_ev, frame_take, chg_ev;
  logic [DROP_W-1:0] drop_cnt;
  logic [31:0]      stat_word;
  logic             unused_bits;

  assign sel        = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl    = bus_wr && (sel == SEL_CTRL);
  assign wr_stat    = bus_wr && (sel == SEL_STAT);
  assign rd_stat    = bus_rd && (sel == SEL_STAT);
  assign hold_clear = !ctrl_q[0] || !cable_in;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:4]};

  tricap_seq i_seq (
    .clk(clk), .rst_n(rst_n), .hold_clear(hold_clear), .frame_rdy(frame_rdy),
    .dma_done(dma_done), .pend_idx(pend_idx), .done_ev(done_ev),
    .drop_ev(drop_ev), .frame_take(frame_take)
  );

  tricap_dropcnt #(.CNT_W(DROP_W)) i_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop_ev), .clr(rd_stat), .count(drop_cnt)
  );

  tricap_cable i_cable (
    .clk(clk), .rst_n(rst_n), .cable_in(cable_in), .chg_ev(chg_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
      done_q <= (done_q && !(wr_stat && bus_wdata[ST_DONE_BIT])) || done_ev;
      chg_q  <= (chg_q && !(wr_stat && bus_wdata[ST_CHG_BIT])) || chg_ev;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[POS_W-1:0] = pend_idx;
    stat_word[ST_DONE_BIT] = done_q;
    stat_word[ST_CHG_BIT] = chg_q;
    stat_word[ST_DROP_LSB +: DROP_W] = drop_cnt;
  end

  always_comb begin
    unique case (sel)
      SEL_FSIZE: bus_rdata = FRAME_PAGES;
      SEL_CTRL:  bus_rdata = {30'd0, ctrl_q};
      SEL_STAT:  bus_rdata = stat_word;
      default:   bus_rdata = {31'd0, cable_in};
    endcase
  end

  assign irq = (ctrl_q[0] && (pend_idx != '0 || done_q)) || (ctrl_q[1] && chg_q);

  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> done_q);

  assert_chg_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ev |=> chg_q);

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[ST_DONE_BIT] && !done_ev) |=> !done_q);
endmodule

// File: tb/test_tri_capture_ctl.sv
`timescale 1ns/1ps
module test_tri_capture_ctl;
  localparam logic [31:0] PAGES = 32'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic frame_rdy = 1'b0, dma_done = 1'b0, cable_in = 1'b1;
  logic irq;

  tri_capture_ctl #(.FRAME_PAGES(PAGES)) i_tri_capture_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_rdy(frame_rdy),
    .dma_done(dma_done), .cable_in(cable_in), .irq(irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cap = 0, m_xfr = 0, m_drop = 0, m_ctrl = 0;
  bit m_done = 0, m_chg = 0, m_prev = 0, m_valid = 0;

  function automatic int m_pend();
    return (m_xfr < m_cap) ? m_xfr + 1 : 0;
  endfunction

  function automatic logic [31:0] m_reg(input logic [3:0] a);
    case (a[3:2])
      2'd0: return PAGES;
      2'd1: return 32'(m_ctrl);
      2'd2: return 32'(m_pend()) | (32'(m_done) << 2) | (32'(m_chg) << 3) | (32'(m_drop) << 8);
      default: return {31'd0, cable_in};
    endcase
  endfunction

  function automatic bit m_irq();
    return ((m_ctrl & 1) != 0 && (m_pend() != 0 || m_done)) || ((m_ctrl & 2) != 0 && m_chg);
  endfunction

  task automatic model_step();
    bit dn_ev, dr_ev, ch_ev, stat_sel;
    dn_ev = 0; dr_ev = 0;
    stat_sel = (bus_addr[3:2] == 2'd2);
    if ((m_ctrl & 1) == 0 || !cable_in) begin
      m_cap = 0; m_xfr = 0;
    end else begin
      if (dma_done && m_xfr < m_cap) begin m_xfr++; dn_ev = 1; end
      if (frame_rdy) begin
        if (m_cap == 3) begin dr_ev = (m_xfr < 3); m_cap = 1; m_xfr = 0; end
        else m_cap++;
      end
    end
    if (bus_rd && stat_sel) m_drop = dr_ev ? 1 : 0;
    else if (dr_ev && m_drop < 255) m_drop++;
    ch_ev = m_valid && (cable_in != m_prev);
    m_prev = cable_in; m_valid = 1;
    if (bus_wr && stat_sel) begin
      if (bus_wdata[2]) m_done = 0;
      if (bus_wdata[3]) m_chg = 0;
    end
    if (dn_ev) m_done = 1;
    if (ch_ev) m_chg = 1;
    if (bus_wr && bus_addr[3:2] == 2'd1) m_ctrl = int'(bus_wdata[1:0]);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, irq compared every cycle (R10)
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    frame_rdy = 0; dma_done = 0; bus_wr = 0; bus_rd = 0;
    check("R10 irq", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic op(input bit fr, input bit dn, input bit wr, input bit rd,
                    input logic [3:0] a, input logic [31:0] d, input string tag);
    frame_rdy = fr; dma_done = dn; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    if (rd) check(tag, bus_rdata, m_reg(a));
    tick();
  endtask

  task automatic frame();  op(1, 0, 0, 0, 4'h0, 0, ""); endtask
  task automatic xfer();   op(0, 1, 0, 0, 4'h0, 0, ""); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); op(0, 0, 1, 0, a, d, ""); endtask
  task automatic rd(input logic [3:0] a, input string tag); op(0, 0, 0, 1, a, 0, tag); endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    rst_n = 1;
    rd(4'h0, "R2 frame size");
    rd(4'h4, "R1 ctrl reset");
    rd(4'h8, "R1 status reset");
    rd(4'hC, "R9 cable level");
    wr(4'h4, 32'hFFFF_FFFE);
    rd(4'h4, "R2 ctrl readback");
    // buffering off: frames ignored
    wr(4'h4, 0);
    frame(); rd(4'h8, "R8 frame ignored while disabled");
    wr(4'h4, 1);
    frame(); rd(4'h8, "R3 first frame pending");
    frame(); frame(); rd(4'h8, "R3 oldest stays pending");
    xfer(); rd(4'h8, "R4 advance after transfer");
    wr(4'h8, 32'h4); rd(4'h8, "R5 done cleared");
    xfer(); xfer(); rd(4'h8, "R4 set fully moved");
    xfer(); rd(4'h8, "R4 transfer with nothing pending");
    frame(); rd(4'h8, "R6 new set without drop");
    // collision: last transfer with next set's frame
    frame(); frame(); xfer(); xfer();
    op(1, 1, 0, 0, 4'h0, 0, ""); rd(4'h8, "R6 transfer and frame together");
    // drop
    frame(); frame(); rd(4'h8, "R3 before drop");
    frame(); rd(4'h8, "R6 drop counted");
    rd(4'h8, "R7 cleared by read");
    // set wins over clear
    op(0, 1, 1, 0, 4'h8, 32'h4, ""); rd(4'h8, "R5 set wins");
    // read colliding with a drop
    frame(); frame(); frame(); frame(); frame();
    op(1, 0, 0, 1, 4'h8, 0, "R7 read during drop"); rd(4'h8, "R7 drop after read");
    // saturation
    for (int k = 0; k < 800; k++) frame();
    rd(4'h8, "R7 saturated");
    rd(4'h8, "R7 cleared after saturation");
    // flush by disabling
    frame(); wr(4'h4, 2); rd(4'h8, "R8 flushed");
    wr(4'h4, 3); rd(4'h8, "R8 no refill without frames");
    // cable removal
    frame(); frame();
    cable_in = 0; tick();
    rd(4'h8, "R9 cable change and state cleared");
    rd(4'hC, "R9 cable absent");
    frame(); rd(4'h8, "R9 frames ignored while absent");
    wr(4'h8, 32'h8); rd(4'h8, "R5 change flag cleared");
    cable_in = 1; tick();
    rd(4'h8, "R9 reconnect flagged");
    wr(4'h4, 1); rd(4'h8, "R10 cable irq masked");
    frame(); rd(4'h8, "R3 capture after reconnect");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule